// File: doc/BRIEF.md
# Programmable LCD panel timing generator

This block drives the timing side of a parallel LCD panel. From the LCD functional clock it derives a pixel-clock enable through a programmable divider. Each pixel period it steps a horizontal phase machine, and each completed line steps a vertical phase machine. From these two machines it produces horizontal and vertical sync, a data-enable for active video, the pixel coordinates inside the active area, and two single-cycle strobes: one at the start of each vertical sync and one at the end of each active line. Passive panels also get an AC-bias signal that toggles after a programmable number of active lines.

Three 32-bit timing words configure the block: horizontal, vertical and auxiliary. Software writes them while `enable` is low. The block holds at the top of the frame while disabled and starts with the first sync pixel when `enable` rises. Dropping `enable` at any time returns the block to the top of the frame. Each axis runs the same four-phase sequence: sync, then back porch, then active, then front porch. The states are PH_SYNC, PH_BACK, PH_ACTIVE and PH_FRONT. At the last unit of a phase the machine takes one of these transitions:
- SYNC→BACK when the back porch is non-empty, otherwise SYNC→ACTIVE.
- BACK→ACTIVE.
- ACTIVE→FRONT when the front porch is non-empty, otherwise ACTIVE→SYNC.
- FRONT→SYNC.

Only the vertical porches can be empty.

Top module: `lcd_timing_gen`

## Requirements
- R1: While `enable` is low, `pix_ce`, `frame_stb`, `line_end_stb`, `px_x` and `px_y` are 0. Each of `vsync`, `hsync`, `data_en` and `ac_bias` equals its invert bit (R9). `ac_bias` reaches that level one cycle after `enable` falls.
- R2: The divider field is aux bits 7:0. The effective divider D is this field raised to a floor of 2 when `active_matrix`=1, or 3 when it is 0. The 8-bit field caps D at 255. `pix_ce` is high in the enabled cycles k = D-1, 2D-1, … counted from 0 at the cycle `enable` is seen high.
- R3: A line has four phases in this order: hsync for horiz[15:10]+1 pixels, back porch for horiz[31:24]+1 pixels, active for horiz[9:0]+1 pixels, front porch for horiz[23:16]+1 pixels. `hsync` is high during the sync phase.
- R4: A frame has four phases in this order: vsync for vert[15:10]+1 lines, back porch for vert[31:24] lines, active for vert[9:0]+1 lines, front porch for vert[23:16] lines. A porch of 0 lines is skipped. `vsync` is high during the sync phase.
- R5: `data_en` is high only when both axes are in their active phase. Then `px_x` and `px_y` give the pixel and line index within the active area. Both are 0 otherwise.
- R6: `frame_stb` is high for exactly the first clock cycle of every vsync assertion, including the first one after `enable` rises.
- R7: `line_end_stb` is high for exactly the first clock cycle after each active line ends, which is the first cycle of that line's front porch.
- R8: When `active_matrix`=0, `ac_bias` toggles once per M line-end strobes, where M is aux bits 15:8 and a value of 0 counts as 1. The toggle is visible the cycle after the M-th strobe. When `active_matrix`=1, `ac_bias` stays at its idle level.
- R9: Aux bit 20 inverts `vsync`, bit 21 inverts `hsync`, bit 22 inverts `data_en` and bit 23 inverts `ac_bias`. Aux bits 24 and 25 have no effect on any output.
- R10: Lowering `enable` in the middle of a frame and raising it again restarts timing from the first sync pixel of line 0, using the timing words present at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LCD functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the timing; low holds at top of frame |
| active_matrix | input | 1 | 1 for active-matrix panel, 0 for passive |
| horiz_cfg | input | 32 | Horizontal timing word |
| vert_cfg | input | 32 | Vertical timing word |
| aux_cfg | input | 32 | Divider, AC-bias count, invert bits |
| pix_ce | output | 1 | One-cycle pixel clock enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| data_en | output | 1 | Active video |
| ac_bias | output | 1 | AC-bias toggle for passive panels |
| px_x | output | 10 | Pixel index in active line |
| px_y | output | 10 | Line index in active area |
| frame_stb | output | 1 | First cycle of each vsync |
| line_end_stb | output | 1 | First cycle after each active line |

## Verification
The following outputs change in the same clock cycle as the phase registers, one cycle after the `pix_ce` cycle that advanced them: `hsync`, `vsync`, `data_en`, the coordinates and both strobes. The phase registers therefore show pixel index floor(t/D) at the t-th enabled cycle. `ac_bias` lags one more cycle behind the strobe that toggles it. Lowering `enable` clears every output in the same cycle except `ac_bias`, which clears at the next edge. The bench derives each output from t, D and the programmed phase lengths with closed-form arithmetic. It samples one nanosecond after each falling edge and checks `ac_bias` one cycle after disable.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } phase_e;

    // field positions shared by both axis words
    localparam int ACT_LSB   = 0;
    localparam int ACT_W     = 10;
    localparam int SYNC_LSB  = 10;
    localparam int SYNC_W    = 6;
    localparam int FP_LSB    = 16;
    localparam int BP_LSB    = 24;
    localparam int PORCH_W   = 8;

    // auxiliary word
    localparam int DIV_LSB   = 0;
    localparam int DIV_W     = 8;
    localparam int ACB_LSB   = 8;
    localparam int ACB_W     = 8;
    localparam int INV_VS    = 20;
    localparam int INV_HS    = 21;
    localparam int INV_DE    = 22;
    localparam int INV_AC    = 23;

endpackage

// File: rtl/lcdt_pixdiv.sv
module lcdt_pixdiv #(
    parameter int DIV_W     = 8,
    parameter int AM_FLOOR  = 2,
    parameter int PV_FLOOR  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             active_matrix,
    input  logic [DIV_W-1:0] div_field,
    output logic             pix_ce
);
    localparam logic [DIV_W-1:0] AMF = DIV_W'(AM_FLOOR);
    localparam logic [DIV_W-1:0] PVF = DIV_W'(PV_FLOOR);

    logic [DIV_W-1:0] floor_v;
    logic [DIV_W-1:0] d_eff;
    logic [DIV_W-1:0] d_last;
    logic [DIV_W-1:0] cnt;

    always_comb begin
        floor_v = active_matrix ? AMF : PVF;
        d_eff   = (div_field < floor_v) ? floor_v : div_field;
        d_last  = d_eff - DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (cnt >= d_last)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end

    assign pix_ce = run && (cnt >= d_last);

    // R2
    ce_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ce |=> !pix_ce);

endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis
    import lcdt_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [LEN_W-1:0] sync_len,
    input  logic [LEN_W-1:0] back_len,
    input  logic [LEN_W-1:0] act_len,
    input  logic [LEN_W-1:0] front_len,
    output phase_e           phase,
    output logic [LEN_W-1:0] pos,
    output logic             wrap
);
    phase_e           st, st_n;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] cur_len;
    logic             last;

    always_comb begin
        cur_len = sync_len;
        st_n    = PH_SYNC;
        unique case (st)
            PH_SYNC: begin
                cur_len = sync_len;
                st_n    = (back_len != '0) ? PH_BACK : PH_ACTIVE;
            end
            PH_BACK: begin
                cur_len = back_len;
                st_n    = PH_ACTIVE;
            end
            PH_ACTIVE: begin
                cur_len = act_len;
                st_n    = (front_len != '0) ? PH_FRONT : PH_SYNC;
            end
            PH_FRONT: begin
                cur_len = front_len;
                st_n    = PH_SYNC;
            end
        endcase
        last = (cnt >= cur_len - LEN_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= PH_SYNC;
            cnt <= '0;
        end else if (!run) begin
            st  <= PH_SYNC;
            cnt <= '0;
        end else if (step) begin
            if (last) begin
                st  <= st_n;
                cnt <= '0;
            end else begin
                cnt <= cnt + LEN_W'(1);
            end
        end
    end

    always_comb begin
        phase = st;
        pos   = cnt;
        wrap  = run && step && last && (st_n == PH_SYNC);
    end

    // R3
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && st == PH_ACTIVE) |-> (cnt < act_len));

    // R4
    wrap_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> (st == PH_FRONT || (st == PH_ACTIVE && front_len == '0)));

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdt_pkg::*;
#(
    parameter int CFG_W = 32,
    parameter int POS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             active_matrix,
    input  logic [CFG_W-1:0] horiz_cfg,
    input  logic [CFG_W-1:0] vert_cfg,
    input  logic [CFG_W-1:0] aux_cfg,
    output logic             pix_ce,
    output logic             hsync,
    output logic             vsync,
    output logic             data_en,
    output logic             ac_bias,
    output logic [POS_W-1:0] px_x,
    output logic [POS_W-1:0] px_y,
    output logic             frame_stb,
    output logic             line_end_stb
);
    localparam int LEN_W = POS_W + 1;

    // phase lengths: horizontal fields all carry a minus-one offset,
    // vertical porches are taken as stored
    logic [LEN_W-1:0] h_sync_len, h_back_len, h_act_len, h_front_len;
    logic [LEN_W-1:0] v_sync_len, v_back_len, v_act_len, v_front_len;

    always_comb begin
        h_sync_len  = LEN_W'(horiz_cfg[SYNC_LSB +: SYNC_W])  + LEN_W'(1);
        h_back_len  = LEN_W'(horiz_cfg[BP_LSB   +: PORCH_W]) + LEN_W'(1);
        h_act_len   = LEN_W'(horiz_cfg[ACT_LSB  +: ACT_W])   + LEN_W'(1);
        h_front_len = LEN_W'(horiz_cfg[FP_LSB   +: PORCH_W]) + LEN_W'(1);
        v_sync_len  = LEN_W'(vert_cfg[SYNC_LSB  +: SYNC_W])  + LEN_W'(1);
        v_back_len  = LEN_W'(vert_cfg[BP_LSB    +: PORCH_W]);
        v_act_len   = LEN_W'(vert_cfg[ACT_LSB   +: ACT_W])   + LEN_W'(1);
        v_front_len = LEN_W'(vert_cfg[FP_LSB    +: PORCH_W]);
    end

    logic             ce;
    logic             h_wrap, v_wrap_unused;
    phase_e           h_phase, v_phase;
    logic [LEN_W-1:0] h_pos, v_pos;

    lcdt_pixdiv #(.DIV_W(DIV_W), .AM_FLOOR(2), .PV_FLOOR(3)) u_div (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (enable),
        .active_matrix (active_matrix),
        .div_field     (aux_cfg[DIV_LSB +: DIV_W]),
        .pix_ce        (ce)
    );

    lcdt_axis #(.LEN_W(LEN_W)) u_haxis (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (enable),
        .step      (ce),
        .sync_len  (h_sync_len),
        .back_len  (h_back_len),
        .act_len   (h_act_len),
        .front_len (h_front_len),
        .phase     (h_phase),
        .pos       (h_pos),
        .wrap      (h_wrap)
    );

    lcdt_axis #(.LEN_W(LEN_W)) u_vaxis (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (enable),
        .step      (h_wrap),
        .sync_len  (v_sync_len),
        .back_len  (v_back_len),
        .act_len   (v_act_len),
        .front_len (v_front_len),
        .phase     (v_phase),
        .pos       (v_pos),
        .wrap      (v_wrap_unused)
    );

    logic hs_raw, vs_raw, de_raw;
    logic vs_q, de_q;
    logic le_stb;
    logic ac_q;
    logic [ACB_W-1:0] ac_cnt;
    logic [ACB_W-1:0] ac_m;

    always_comb begin
        hs_raw = enable && (h_phase == PH_SYNC);
        vs_raw = enable && (v_phase == PH_SYNC);
        de_raw = enable && (h_phase == PH_ACTIVE) && (v_phase == PH_ACTIVE);
        le_stb = enable && de_q && !de_raw;
        ac_m   = (aux_cfg[ACB_LSB +: ACB_W] == '0) ? ACB_W'(1)
                                                   : aux_cfg[ACB_LSB +: ACB_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vs_q <= 1'b0;
            de_q <= 1'b0;
        end else begin
            vs_q <= vs_raw;
            de_q <= de_raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ac_q   <= 1'b0;
            ac_cnt <= '0;
        end else if (!enable || active_matrix) begin
            ac_q   <= 1'b0;
            ac_cnt <= '0;
        end else if (le_stb) begin
            if (ac_cnt >= ac_m - ACB_W'(1)) begin
                ac_cnt <= '0;
                ac_q   <= ~ac_q;
            end else begin
                ac_cnt <= ac_cnt + ACB_W'(1);
            end
        end
    end

    always_comb begin
        pix_ce       = ce;
        hsync        = hs_raw ^ aux_cfg[INV_HS];
        vsync        = vs_raw ^ aux_cfg[INV_VS];
        data_en      = de_raw ^ aux_cfg[INV_DE];
        ac_bias      = ac_q   ^ aux_cfg[INV_AC];
        px_x         = de_raw ? h_pos[POS_W-1:0] : '0;
        px_y         = de_raw ? v_pos[POS_W-1:0] : '0;
        frame_stb    = vs_raw && !vs_q;
        line_end_stb = le_stb;
    end

    logic unused_bits;
    assign unused_bits = ^{aux_cfg[CFG_W-1:24], aux_cfg[19:16],
                           h_pos[LEN_W-1], v_pos[LEN_W-1], v_wrap_unused};

    // R5
    de_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_raw && de_raw));

    // R6
    frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> !frame_stb);

    // R7
    line_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_end_stb |-> (h_phase == PH_FRONT));

    // R8
    ac_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && !active_matrix && (ac_q != $past(ac_q)))
            |-> $past(le_stb));

endmodule

// File: tb/lcd_timing_gen_bench.sv
`timescale 1ns/1ps
module lcd_timing_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        active_matrix = 1'b1;
    logic [31:0] horiz_cfg = '0;
    logic [31:0] vert_cfg = '0;
    logic [31:0] aux_cfg = '0;
    logic        pix_ce, hsync, vsync, data_en, ac_bias;
    logic [9:0]  px_x, px_y;
    logic        frame_stb, line_end_stb;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    lcd_timing_gen u_lcd_timing_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .active_matrix(active_matrix),
        .horiz_cfg(horiz_cfg), .vert_cfg(vert_cfg), .aux_cfg(aux_cfg),
        .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync), .data_en(data_en),
        .ac_bias(ac_bias), .px_x(px_x), .px_y(px_y),
        .frame_stb(frame_stb), .line_end_stb(line_end_stb)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic int eff_div(int dv, int am);
        int fl;
        fl = am ? 2 : 3;
        return (dv < fl) ? fl : dv;
    endfunction

    // idle check: raw levels 0, so each output equals its invert bit
    task automatic chk_idle(input string tag, input int inv);
        chk(pix_ce == 0, {tag, " pix_ce idle"}, pix_ce, 0);
        chk(vsync == inv[0], {tag, " vsync idle"}, vsync, inv[0]);
        chk(hsync == inv[1], {tag, " hsync idle"}, hsync, inv[1]);
        chk(data_en == inv[2], {tag, " data_en idle"}, data_en, inv[2]);
        chk(ac_bias == inv[3], {tag, " ac_bias idle"}, ac_bias, inv[3]);
        chk(frame_stb == 0 && line_end_stb == 0, {tag, " strobes idle"},
            frame_stb + line_end_stb, 0);
        chk(px_x == 0 && px_y == 0, {tag, " coords idle"}, px_x + px_y, 0);
    endtask

    task automatic run_cfg(input int dv, input int am, input int hsw, input int hbp,
                           input int ppl, input int hfp, input int vsw, input int vbp,
                           input int lpp, input int vfp, input int acb, input int inv,
                           input int extra);
        int d, hs, hb, ha, hf, ll, vs, vb, va, vf, ff, ncyc, le_cnt, m;
        d  = eff_div(dv, am);
        hs = hsw + 1; hb = hbp + 1; ha = ppl + 1; hf = hfp + 1;
        ll = hs + hb + ha + hf;
        vs = vsw + 1; vb = vbp; va = lpp + 1; vf = vfp;
        ff = vs + vb + va + vf;
        m  = (acb == 0) ? 1 : acb;
        ncyc = 2 * d * ll * ff + extra;
        if (ncyc > 5200) ncyc = 5200;
        le_cnt = 0;
        @(negedge clk);
        active_matrix = am[0];
        horiz_cfg = {hbp[7:0], hfp[7:0], hsw[5:0], ppl[9:0]};
        vert_cfg  = {vbp[7:0], vfp[7:0], vsw[5:0], lpp[9:0]};
        aux_cfg   = {6'b0, inv[5:0], 4'b0, acb[7:0], dv[7:0]};
        @(negedge clk);
        enable = 1'b1;
        for (int t = 0; t < ncyc; t++) begin
            int p, ph, ln, x, y;
            bit e_hs, e_vs, e_de, e_fs, e_le, e_ce, e_ac, hact, vact;
            #1;
            p  = t / d;
            ph = p % ll;
            ln = (p / ll) % ff;
            hact = (ph >= hs + hb) && (ph < hs + hb + ha);
            vact = (ln >= vs + vb) && (ln < vs + vb + va);
            e_ce = (t % d) == (d - 1);
            e_hs = ph < hs;
            e_vs = ln < vs;
            e_de = hact && vact;
            x = e_de ? ph - hs - hb : 0;
            y = e_de ? ln - vs - vb : 0;
            e_fs = ((t % d) == 0) && (ph == 0) && (ln == 0);
            e_le = ((t % d) == 0) && vact && (ph == hs + hb + ha);
            e_ac = am ? 1'b0 : 1'(((le_cnt / m) % 2));
            chk(pix_ce == e_ce, "R2 pix_ce", pix_ce, e_ce);
            chk(hsync == (e_hs ^ inv[1]), "R3 hsync", hsync, e_hs ^ inv[1]);
            chk(vsync == (e_vs ^ inv[0]), "R4 vsync", vsync, e_vs ^ inv[0]);
            chk(data_en == (e_de ^ inv[2]), "R5 data_en", data_en, e_de ^ inv[2]);
            chk(px_x == x[9:0], "R5 px_x", px_x, x);
            chk(px_y == y[9:0], "R5 px_y", px_y, y);
            chk(frame_stb == e_fs, "R6 frame_stb", frame_stb, e_fs);
            chk(line_end_stb == e_le, "R7 line_end_stb", line_end_stb, e_le);
            chk(ac_bias == (e_ac ^ inv[3]), "R8 ac_bias (R9 invert)", ac_bias, e_ac ^ inv[3]);
            if (e_le) le_cnt++;
            @(negedge clk);
        end
        // R10: drop enable mid-frame, outputs idle, next run restarts at top
        enable = 1'b0;
        @(negedge clk);
        #1;
        chk_idle("R10 R1 after disable", inv);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed1);
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk_idle("R1 in reset", 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk_idle("R1 after reset", 0);

        // directed corners
        // R2 floor active-matrix: field 0 -> D=2
        run_cfg(0, 1, 0, 0, 3, 0, 0, 1, 2, 1, 0, 0, 7);
        // R2 floor passive: field 1 -> D=3, R8 toggle every 2 lines
        run_cfg(1, 0, 1, 0, 2, 1, 0, 0, 3, 0, 2, 0, 11);
        // R4 both vertical porches zero, R9 all inverts plus reserved bits 24,25
        run_cfg(2, 1, 0, 1, 1, 0, 1, 0, 1, 0, 0, 6'b111111, 5);
        // R9 reserved bits only, no invert effect
        run_cfg(4, 0, 0, 0, 2, 0, 0, 2, 1, 2, 0, 6'b110000, 3);
        // R2 maximum divider 255
        run_cfg(255, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 9);
        // R8 acb=0 counts as 1, passive
        run_cfg(3, 0, 0, 0, 0, 0, 0, 1, 2, 1, 0, 6'b001000, 4);

        // constrained random
        for (int i = 0; i < 24; i++) begin
            run_cfg($urandom_range(5, 0), $urandom_range(1, 0),
                    $urandom_range(3, 0), $urandom_range(3, 0),
                    $urandom_range(7, 0), $urandom_range(3, 0),
                    $urandom_range(2, 0), $urandom_range(2, 0),
                    $urandom_range(3, 0), $urandom_range(2, 0),
                    $urandom_range(3, 0), $urandom_range(63, 0),
                    $urandom_range(60, 0));
        end
        finish_run();
    end

    initial begin
        repeat (195000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule